// File: doc/BRIEF.md
# Switched-Port Multi-Ported RAM

This block is a multi-ported memory assembled from true dual-port RAM banks and a live-value table. Its ports fall into three kinds: fixed write ports, fixed read ports, and switched groups. A switched group is a set of physical ports that share one mode input. With the mode at 1 the group acts as GW write ports. With the mode at 0 the group acts as GR read ports. GW and GR may differ, and the group has max(GW, GR) physical ports. Every switched group has its own mode input, so groups change role independently of each other.

Each write slot owns one bank for every read slot. An active write stores its data in all of its own banks in one cycle and records its slot number in the live-value table for that address. A read port looks up the table and reads its bank copies in the same cycle, registering both. One cycle later it selects the copy written by the slot that last wrote the address. The block suits designs that need more concurrent accesses than one RAM macro offers. A switched group lets a set of ports that never read and write at the same time share one set of address pins.

Top module: `mpr_switched_ram`

## Requirements
- R1: While reset is asserted, every fixed read output and every switched-group read output is zero.
- R2: An address presented on a fixed read port at a clock edge yields its data on that port after that edge (one cycle of latency). A fixed write port stores its data at an edge only when its enable is 1.
- R3: A read returns the data of the most recent write to the address, whichever write slot made it. Write slots are the fixed write ports and the write-role ports of every group.
- R4: With a group's mode at 1 (write), port p of that group, for p < GW, writes its data to its address when its enable bit is 1, and writes nothing when the bit is 0.
- R5: With a group's mode at 1 (write), every read output of that group is zero in the following cycle. Group ports with index p >= GR always output zero.
- R6: With a group's mode at 0 (read), its enable and write-data inputs change no stored word.
- R7: With a group's mode at 0 (read), port p of that group, for p < GR, returns the word at its address one cycle later. This holds regardless of the mode of any other group.
- R8: A read and a write to the same address in the same cycle return the word held before that write (read-first).
- R9: With a group's mode at 1 (write), its ports with index p >= GW change no stored word, whatever their enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fw_en | input | NWP | Enable per fixed write port |
| fw_addr | input | NWP*AW | Fixed write addresses, port i at bits [i*AW +: AW] |
| fw_data | input | NWP*DW | Fixed write data, port i at bits [i*DW +: DW] |
| fr_addr | input | NRP*AW | Fixed read addresses, port i at bits [i*AW +: AW] |
| fr_data | output | NRP*DW | Fixed read data, one cycle after the address |
| sg_wmode | input | NG | Mode per switched group: 1 = write role, 0 = read role |
| sg_en | input | NG*GP | Write enable per group port, group g port p at bit g*GP+p |
| sg_addr | input | NG*GP*AW | Group port address, used in both roles, slot g*GP+p |
| sg_wdata | input | NG*GP*DW | Group port write data, slot g*GP+p |
| sg_rdata | output | NG*GP*DW | Group port read data, slot g*GP+p |

## Verification
On every cycle, the assertions check three things. The live-value entry of each written address names the slot that wrote it. No two write slots hit one address in the same cycle. A bank read that meets a same-address write returns the old word. They also check that a fixed-port write followed by a read returns the written word, and that a group in write role shows zero on its read outputs. Some behaviours can only be shown by the bench's scenarios, which compare each read against an array model under random group modes. These are that the most recent writer wins across fixed and switched slots, and that disabled, out-of-range and read-role write inputs leave memory untouched. Another is that one group reads while another writes.

// File: rtl/mpr_pkg.sv
package mpr_pkg;

   // width of an index able to name n distinct items (at least one bit)
   function automatic int unsigned idx_bits(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/mpr_tdp_bank.sv
module mpr_tdp_bank #(
   parameter int DW    = 8,
   parameter int AW    = 4,
   parameter int DEPTH = 16
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          a_en,
   input  logic          a_we,
   input  logic [AW-1:0] a_addr,
   input  logic [DW-1:0] a_din,
   output logic [DW-1:0] a_dout,
   input  logic          b_en,
   input  logic          b_we,
   input  logic [AW-1:0] b_addr,
   input  logic [DW-1:0] b_din,
   output logic [DW-1:0] b_dout
);

   logic [DW-1:0] mem [DEPTH];

   // storage array: no reset, either side may store
   always_ff @(posedge clk) begin
      if (a_en && a_we) mem[a_addr] <= a_din;
      if (b_en && b_we) mem[b_addr] <= b_din;
   end

   // registered read ports, old word returned on a same-cycle write
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_dout <= '0;
         b_dout <= '0;
      end else begin
         if (a_en) a_dout <= mem[a_addr];
         if (b_en) b_dout <= mem[b_addr];
      end
   end

   AST_BANK_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (b_en && !b_we && a_en && a_we && a_addr == b_addr) |=> b_dout == $past(mem[b_addr])); // R8

endmodule

// File: rtl/mpr_lvt.sv
module mpr_lvt #(
   parameter int AW    = 4,
   parameter int DEPTH = 16,
   parameter int NW    = 5,
   parameter int NR    = 8,
   parameter int IW    = 3
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NW-1:0]    wr_act,
   input  logic [NW*AW-1:0] wr_addr,
   input  logic [NR*AW-1:0] rd_addr,
   output logic [NR*IW-1:0] rd_sel
);

   logic [IW-1:0] tbl [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int d = 0; d < DEPTH; d++) tbl[d] <= '0;
         rd_sel <= '0;
      end else begin
         for (int w = 0; w < NW; w++)
            if (wr_act[w]) tbl[wr_addr[w*AW +: AW]] <= IW'(w);
         for (int r = 0; r < NR; r++)
            rd_sel[r*IW +: IW] <= tbl[rd_addr[r*AW +: AW]];
      end
   end

   for (genvar w = 0; w < NW; w++) begin : g_chk
      AST_LVT_TRACKS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
         wr_act[w] |=> tbl[$past(wr_addr[w*AW +: AW])] == IW'(w)); // R3
      for (genvar v = w + 1; v < NW; v++) begin : g_pair
         AST_NO_WR_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_act[w] && wr_act[v] && wr_addr[w*AW +: AW] == wr_addr[v*AW +: AW])); // R3
      end
   end

endmodule

// File: rtl/mpr_port_route.sv
module mpr_port_route #(
   parameter int DW  = 8,
   parameter int AW  = 4,
   parameter int NWP = 1,
   parameter int NRP = 2,
   parameter int NG  = 2,
   parameter int GW  = 2,
   parameter int GR  = 3,
   parameter int GP  = 3,
   parameter int NW  = 5,
   parameter int NR  = 8
)(
   input  logic [NWP-1:0]     fw_en,
   input  logic [NWP*AW-1:0]  fw_addr,
   input  logic [NWP*DW-1:0]  fw_data,
   input  logic [NRP*AW-1:0]  fr_addr,
   input  logic [NG-1:0]      sg_wmode,
   input  logic [NG*GP-1:0]   sg_en,
   input  logic [NG*GP*AW-1:0] sg_addr,
   input  logic [NG*GP*DW-1:0] sg_wdata,
   output logic [NW-1:0]      wr_act,
   output logic [NW*AW-1:0]   wr_addr,
   output logic [NW*DW-1:0]   wr_data,
   output logic [NR-1:0]      rd_en,
   output logic [NR*AW-1:0]   rd_addr
);

   // fixed write ports occupy the first write slots
   for (genvar i = 0; i < NWP; i++) begin : g_fw
      assign wr_act[i]             = fw_en[i];
      assign wr_addr[i*AW +: AW]   = fw_addr[i*AW +: AW];
      assign wr_data[i*DW +: DW]   = fw_data[i*DW +: DW];
   end

   // fixed read ports occupy the first read slots and never idle
   for (genvar i = 0; i < NRP; i++) begin : g_fr
      assign rd_en[i]              = 1'b1;
      assign rd_addr[i*AW +: AW]   = fr_addr[i*AW +: AW];
   end

   for (genvar g = 0; g < NG; g++) begin : g_grp
      for (genvar p = 0; p < GP; p++) begin : g_port
         localparam int PS = g*GP + p;
         if (p < GW) begin : g_wr
            localparam int WS = NWP + g*GW + p;
            assign wr_act[WS]           = sg_wmode[g] & sg_en[PS];
            assign wr_addr[WS*AW +: AW] = sg_addr[PS*AW +: AW];
            assign wr_data[WS*DW +: DW] = sg_wdata[PS*DW +: DW];
         end else begin : g_nowr
            logic unused_wr_pins;
            assign unused_wr_pins = sg_en[PS] ^ (^sg_wdata[PS*DW +: DW]);
         end
         if (p < GR) begin : g_rd
            localparam int RS = NRP + g*GR + p;
            assign rd_en[RS]            = ~sg_wmode[g];
            assign rd_addr[RS*AW +: AW] = sg_addr[PS*AW +: AW];
         end
      end
   end

endmodule

// File: rtl/mpr_switched_ram.sv
module mpr_switched_ram
   import mpr_pkg::*;
#(
   parameter int DW  = 8,
   parameter int AW  = 4,
   parameter int NWP = 1,
   parameter int NRP = 2,
   parameter int NG  = 2,
   parameter int GW  = 2,
   parameter int GR  = 3
)(
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [NWP-1:0]                       fw_en,
   input  logic [NWP*AW-1:0]                    fw_addr,
   input  logic [NWP*DW-1:0]                    fw_data,
   input  logic [NRP*AW-1:0]                    fr_addr,
   output logic [NRP*DW-1:0]                    fr_data,
   input  logic [NG-1:0]                        sg_wmode,
   input  logic [NG*max2(GW,GR)-1:0]            sg_en,
   input  logic [NG*max2(GW,GR)*AW-1:0]         sg_addr,
   input  logic [NG*max2(GW,GR)*DW-1:0]         sg_wdata,
   output logic [NG*max2(GW,GR)*DW-1:0]         sg_rdata
);

   localparam int DEPTH = 1 << AW;
   localparam int GP    = max2(GW, GR);
   localparam int NW    = NWP + NG*GW;
   localparam int NR    = NRP + NG*GR;
   localparam int IW    = idx_bits(NW);

   // elaboration-time parameter checks
   if (DW < 1 || AW < 1) begin : g_bad_geom
      $error("mpr_switched_ram: DW and AW must be at least 1");
   end
   if (NWP < 1 || NRP < 1) begin : g_bad_fixed
      $error("mpr_switched_ram: at least one fixed write and one fixed read port");
   end
   if (NG < 1 || GW < 1 || GR < 1) begin : g_bad_group
      $error("mpr_switched_ram: each switched group needs GW >= 1 and GR >= 1");
   end

   logic [NW-1:0]    wr_act;
   logic [NW*AW-1:0] wr_addr;
   logic [NW*DW-1:0] wr_data;
   logic [NR-1:0]    rd_en;
   logic [NR*AW-1:0] rd_addr;
   logic [NR*IW-1:0] rd_sel;

   mpr_port_route #(
      .DW(DW), .AW(AW), .NWP(NWP), .NRP(NRP), .NG(NG),
      .GW(GW), .GR(GR), .GP(GP), .NW(NW), .NR(NR)
   ) u_route (
      .fw_en(fw_en), .fw_addr(fw_addr), .fw_data(fw_data), .fr_addr(fr_addr),
      .sg_wmode(sg_wmode), .sg_en(sg_en), .sg_addr(sg_addr), .sg_wdata(sg_wdata),
      .wr_act(wr_act), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr)
   );

   mpr_lvt #(
      .AW(AW), .DEPTH(DEPTH), .NW(NW), .NR(NR), .IW(IW)
   ) u_lvt (
      .clk(clk), .rst_n(rst_n),
      .wr_act(wr_act), .wr_addr(wr_addr),
      .rd_addr(rd_addr), .rd_sel(rd_sel)
   );

   // bank grid: one bank per (write slot, read slot); side A writes, side B reads
   logic [DW-1:0] bank_q      [NW][NR];
   logic [DW-1:0] unused_a_q  [NW][NR];

   for (genvar w = 0; w < NW; w++) begin : g_wslot
      for (genvar r = 0; r < NR; r++) begin : g_rslot
         mpr_tdp_bank #(
            .DW(DW), .AW(AW), .DEPTH(DEPTH)
         ) u_bank (
            .clk(clk), .rst_n(rst_n),
            .a_en(wr_act[w]), .a_we(wr_act[w]),
            .a_addr(wr_addr[w*AW +: AW]), .a_din(wr_data[w*DW +: DW]),
            .a_dout(unused_a_q[w][r]),
            .b_en(rd_en[r]), .b_we(1'b0),
            .b_addr(rd_addr[r*AW +: AW]), .b_din({DW{1'b0}}),
            .b_dout(bank_q[w][r])
         );
      end
   end

   // live-value select picks the copy of the last writer
   logic [DW-1:0] rdat [NR];

   always_comb begin
      for (int r = 0; r < NR; r++) begin
         rdat[r] = '0;
         for (int w = 0; w < NW; w++)
            if (rd_sel[r*IW +: IW] == IW'(w)) rdat[r] = bank_q[w][r];
      end
   end

   for (genvar r = 0; r < NRP; r++) begin : g_fout
      assign fr_data[r*DW +: DW] = rdat[r];
   end

   // a group's read outputs are live only after a read-role cycle
   logic [NG-1:0] rd_live_q;
   logic          past_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_live_q <= '0;
         past_ok   <= 1'b0;
      end else begin
         rd_live_q <= ~sg_wmode;
         past_ok   <= 1'b1;
      end
   end

   for (genvar g = 0; g < NG; g++) begin : g_gout
      for (genvar p = 0; p < GP; p++) begin : g_port
         if (p < GR) begin : g_live
            assign sg_rdata[(g*GP+p)*DW +: DW] = rd_live_q[g] ? rdat[NRP + g*GR + p] : '0;
         end else begin : g_dead
            assign sg_rdata[(g*GP+p)*DW +: DW] = '0;
         end
      end
      AST_WMODE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
         (past_ok && $past(sg_wmode[g])) |-> sg_rdata[g*GP*DW +: GP*DW] == '0); // R5
   end

   AST_WRITE_THEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(fw_en[0]) && fr_addr[AW-1:0] == $past(fw_addr[AW-1:0]))
      |=> fr_data[DW-1:0] == $past(fw_data[DW-1:0], 2)); // R2

endmodule

// File: tb/sim_mpr_switched_ram.sv
`timescale 1ns/1ps
module sim_mpr_switched_ram;

   localparam int DW = 8, AW = 4, NWP = 1, NRP = 2, NG = 2, GW = 2, GR = 3;
   localparam int GP = (GW > GR) ? GW : GR;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NWP-1:0]        fw_en = '0;
   logic [NWP*AW-1:0]     fw_addr = '0;
   logic [NWP*DW-1:0]     fw_data = '0;
   logic [NRP*AW-1:0]     fr_addr = '0;
   logic [NRP*DW-1:0]     fr_data;
   logic [NG-1:0]         sg_wmode = '0;
   logic [NG*GP-1:0]      sg_en = '0;
   logic [NG*GP*AW-1:0]   sg_addr = '0;
   logic [NG*GP*DW-1:0]   sg_wdata = '0;
   logic [NG*GP*DW-1:0]   sg_rdata;

   always #2 clk = ~clk;

   mpr_switched_ram #(.DW(DW), .AW(AW), .NWP(NWP), .NRP(NRP), .NG(NG), .GW(GW), .GR(GR)) u0 (
      .clk(clk), .rst_n(rst_n),
      .fw_en(fw_en), .fw_addr(fw_addr), .fw_data(fw_data),
      .fr_addr(fr_addr), .fr_data(fr_data),
      .sg_wmode(sg_wmode), .sg_en(sg_en), .sg_addr(sg_addr),
      .sg_wdata(sg_wdata), .sg_rdata(sg_rdata)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [DW-1:0] mdl [DEPTH];

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
      end
   endtask

   task automatic set_ga(input int g, input int p, input logic [AW-1:0] a);
      sg_addr[(g*GP+p)*AW +: AW] = a;
   endtask

   task automatic set_gd(input int g, input int p, input logic [DW-1:0] d);
      sg_wdata[(g*GP+p)*DW +: DW] = d;
   endtask

   task automatic idle();
      fw_en = '0; sg_wmode = '0; sg_en = '0; sg_wdata = '0;
   endtask

   // one clock: expectations from the model, edge, model update, compare
   task automatic run_cycle(input string tag);
      logic [DW-1:0] ef [NRP];
      logic [DW-1:0] eg [NG*GP];
      for (int r = 0; r < NRP; r++) ef[r] = mdl[fr_addr[r*AW +: AW]];
      for (int g = 0; g < NG; g++)
         for (int p = 0; p < GP; p++)
            eg[g*GP+p] = (!sg_wmode[g] && p < GR) ? mdl[sg_addr[(g*GP+p)*AW +: AW]] : '0;
      @(posedge clk);
      for (int i = 0; i < NWP; i++)
         if (fw_en[i]) mdl[fw_addr[i*AW +: AW]] = fw_data[i*DW +: DW];
      for (int g = 0; g < NG; g++)
         for (int p = 0; p < GW; p++)
            if (sg_wmode[g] && sg_en[g*GP+p])
               mdl[sg_addr[(g*GP+p)*AW +: AW]] = sg_wdata[(g*GP+p)*DW +: DW];
      @(negedge clk);
      for (int r = 0; r < NRP; r++)
         chk(tag, $sformatf("fixed read %0d", r), 32'(fr_data[r*DW +: DW]), 32'(ef[r]));
      for (int k = 0; k < NG*GP; k++)
         chk(tag, $sformatf("group slot %0d", k), 32'(sg_rdata[k*DW +: DW]), 32'(eg[k]));
   endtask

   // directed vectors on fixed port 0: {wen, waddr, wdata, raddr, expected}
   // memory holds 8'hA0|addr after initialisation
   localparam logic [24:0] DIR_TAB [8] = '{
      {1'b1, 4'd3, 8'h11, 4'd3, 8'hA3},   // R8 read-first
      {1'b0, 4'd3, 8'h00, 4'd3, 8'h11},   // R2 one-cycle latency
      {1'b1, 4'd5, 8'h22, 4'd4, 8'hA4},   // R2 other address untouched
      {1'b0, 4'd0, 8'h00, 4'd5, 8'h22},   // R2
      {1'b1, 4'd5, 8'h33, 4'd5, 8'h22},   // R8 overwrite, old word seen
      {1'b0, 4'd0, 8'h00, 4'd5, 8'h33},   // R2
      {1'b0, 4'd6, 8'h44, 4'd6, 8'hA6},   // R2 enable low stores nothing
      {1'b0, 4'd0, 8'h00, 4'd6, 8'hA6}    // R2
   };

   initial begin
      #(200000 * 4);
      if (!done) begin
         fails++;
         $display("FAIL watchdog act=running exp=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      // reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", "fixed reads in reset", 32'(fr_data), 32'h0);
      chk("R1", "group reads in reset", 32'(sg_rdata[31:0]), 32'h0);
      chk("R1", "group reads in reset hi", 32'(sg_rdata[NG*GP*DW-1:32]), 32'h0);
      rst_n = 1'b1;

      // initialise every word through fixed port 0, groups in write role idle
      sg_wmode = '1;
      for (int a = 0; a < DEPTH; a++) begin
         fw_en = 1'b1; fw_addr = AW'(a); fw_data = {4'hA, 4'(a)};
         fr_addr = {2{AW'((a + 1) % DEPTH)}};
         @(posedge clk);
         mdl[a] = {4'hA, 4'(a)};
         @(negedge clk);
      end
      idle();
      fr_addr = '0;
      @(negedge clk);

      // table walk
      for (int i = 0; i < 8; i++) begin
         fw_en = DIR_TAB[i][24]; fw_addr = DIR_TAB[i][23:20];
         fw_data = DIR_TAB[i][19:12]; fr_addr[AW-1:0] = DIR_TAB[i][11:8];
         @(posedge clk);
         if (fw_en[0]) mdl[fw_addr] = fw_data;
         @(negedge clk);
         chk("R2,R8", $sformatf("table row %0d", i), 32'(fr_data[DW-1:0]), 32'(DIR_TAB[i][7:0]));
      end
      idle();

      // R3: last writer wins across slot kinds
      sg_wmode[0] = 1'b1; sg_en[1] = 1'b1; set_ga(0, 1, 4'd7); set_gd(0, 1, 8'h5C);
      fr_addr[AW-1:0] = 4'd7;
      run_cycle("R3");
      idle(); run_cycle("R3");
      fw_en = 1'b1; fw_addr = 4'd7; fw_data = 8'h6D; run_cycle("R3");
      idle(); set_ga(1, 2, 4'd7); run_cycle("R3");

      // R4: write role, enable low
      sg_wmode[1] = 1'b1; set_ga(1, 0, 4'd9); set_gd(1, 0, 8'hFF); set_ga(0, 0, 4'd9);
      run_cycle("R4");
      idle(); fr_addr[AW-1:0] = 4'd9; run_cycle("R4");
      chk("R4", "addr 9 after disabled write", 32'(fr_data[DW-1:0]), 32'hA9);

      // R9: port beyond GW ignored in write role
      sg_wmode[1] = 1'b1; sg_en[GP+2] = 1'b1; set_ga(1, 2, 4'd10); set_gd(1, 2, 8'hEE);
      run_cycle("R9");
      idle(); fr_addr[AW-1:0] = 4'd10; run_cycle("R9");
      chk("R9", "addr 10 after ignored port", 32'(fr_data[DW-1:0]), 32'hAA);

      // R6: read role ignores enable and data
      sg_en = '1; set_ga(0, 0, 4'd11); set_gd(0, 0, 8'h77); run_cycle("R6");
      idle(); fr_addr[AW-1:0] = 4'd11; run_cycle("R6");
      chk("R6", "addr 11 after read-role inputs", 32'(fr_data[DW-1:0]), 32'hAB);

      // R7: group 0 writes while group 1 reads
      sg_wmode[0] = 1'b1; sg_en[0] = 1'b1; set_ga(0, 0, 4'd12); set_gd(0, 0, 8'h12);
      set_ga(1, 0, 4'd12); set_ga(1, 1, 4'd3);
      run_cycle("R7");
      idle(); run_cycle("R7");
      chk("R7", "group1 port0 reads addr 12", 32'(sg_rdata[GP*DW +: DW]), 32'h12);

      // R5: write role silences group outputs
      sg_wmode = '1; run_cycle("R5");
      chk("R5", "group outputs after write role", 32'(sg_rdata[31:0]), 32'h0);

      // random phase against the model
      for (int n = 0; n < 400; n++) begin
         int base;
         idle();
         base = int'($urandom % DEPTH);
         fw_en = 1'($urandom); fw_addr = AW'(base); fw_data = DW'($urandom);
         fr_addr = NRP*AW'($urandom);
         for (int g = 0; g < NG; g++) begin
            sg_wmode[g] = 1'($urandom);
            for (int p = 0; p < GP; p++) begin
               sg_en[g*GP+p] = 1'($urandom);
               set_gd(g, p, DW'($urandom));
               if (p < GW) set_ga(g, p, AW'((base + 3*(1 + g*GW + p)) % DEPTH));
               else        set_ga(g, p, AW'($urandom));
            end
         end
         run_cycle("R3,R7");
      end

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule